// File: doc/BRIEF.md
# Byte-Order-Selectable Data Memory

This block is a small 32-bit data store in which every byte has its own address. It serves two access sizes: a full word and a single byte. Word addresses step by four bytes. A word is found at the same address whatever byte order is in use.

A one-bit order input chooses how the two low address bits pick a byte lane inside the word. It can change from one access to the next. Byte loads come back sign-extended to 32 bits. A byte store rewrites only its own lane.

A word access whose address is not a multiple of four raises a flag, and such a word store is dropped. Reads are combinational. Writes take effect on the rising clock edge.

Top module: `endian_data_mem`

## Requirements
- R1: While reset is high at a clock edge, every byte of the store is cleared, so any later read returns 0 until something is written.
- R2: A word store (size_i = 1) to an aligned address, followed by a word load from that address, returns the stored 32-bit value. The result is the same with either setting of big_endian_i.
- R3: With big_endian_i = 0, a byte load at an address whose low two bits are k selects bits [8k+7:8k] of the word that holds it.
- R4: With big_endian_i = 1, a byte load at an address whose low two bits are k selects bits [31-8k:24-8k] of the word. So after a word store at address 0, a byte load at address 1 returns bits [15:8] in little order and bits [23:16] in big order.
- R5: A byte load (size_i = 0) returns the selected byte in rdata_o[7:0], with bit 7 copied into rdata_o[31:8].
- R6: A byte store writes wdata_i[7:0] into the lane chosen by R3/R4 and leaves the other three bytes of that word unchanged.
- R7: misalign_o is 1 exactly when size_i = 1 and addr_i[1:0] is nonzero. A word store in that case changes no byte of the store. Byte accesses never raise the flag.
- R8: rdata_o follows the address inputs in the same cycle. A store becomes visible only after the rising clock edge at which we_i is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes happen on its rising edge |
| rst | input | 1 | Synchronous active-high reset that clears the store |
| big_endian_i | input | 1 | Byte order: 1 means byte 0 is the most significant lane |
| addr_i | input | ADDR_W (8) | Byte address |
| size_i | input | 1 | Access size: 1 = word, 0 = byte |
| we_i | input | 1 | Store enable |
| wdata_i | input | 32 | Store data; only bits [7:0] are used for a byte store |
| rdata_o | output | 32 | Load data, combinational |
| misalign_o | output | 1 | Word access with nonzero low address bits |

## Verification
The in-line properties check these on every cycle:
- A flagged access produces no write strobe.
- A byte store enables exactly one lane.
- A full-word store lands intact in the addressed entry.
- A byte load always shows a clean sign extension.

Some behaviour only the bench scenarios can show:
- Which lane each order picks, such as bits [15:8] versus [23:16] for address 1.
- That the untouched lanes keep their bytes after a byte store.
- That a dropped misaligned store really left memory intact.
- That a store stays invisible until its clock edge.

The bench shows these by comparing loads against a byte-level model after directed and random sequences.

// File: rtl/edm_pkg.sv
package edm_pkg;

    localparam int unsigned LANE_W = 8;
    localparam int unsigned LANES  = 4;
    localparam int unsigned WORD_W = LANE_W * LANES;
    localparam int unsigned OFF_W  = $clog2(LANES);

    typedef enum logic {
        ACC_BYTE = 1'b0,
        ACC_WORD = 1'b1
    } acc_size_e;

    typedef enum logic {
        ORD_LITTLE = 1'b0,
        ORD_BIG    = 1'b1
    } byte_order_e;

    // Lane control produced by the address decoder
    typedef struct packed {
        logic [OFF_W-1:0] lane;
        logic             misalign;
        logic [LANES-1:0] strobe;
    } lane_ctl_t;

    // Physical lane for a byte offset under a given order
    function automatic logic [OFF_W-1:0] lane_of(logic [OFF_W-1:0] off, byte_order_e ord);
        return (ord == ORD_BIG) ? ~off : off;
    endfunction

    function automatic logic [WORD_W-1:0] sext_byte(logic [LANE_W-1:0] b);
        return {{(WORD_W-LANE_W){b[LANE_W-1]}}, b};
    endfunction

endpackage

// File: rtl/edm_lane_decode.sv
module edm_lane_decode
    import edm_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    localparam int unsigned IDX_W = ADDR_W - OFF_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  acc_size_e         size_i,
    input  byte_order_e       order_i,
    input  logic              we_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [IDX_W-1:0]  idx_o,
    output lane_ctl_t         ctl_o,
    output logic [WORD_W-1:0] wbus_o
);

    logic [OFF_W-1:0] off;

    always_comb begin
        off            = addr_i[OFF_W-1:0];
        idx_o          = addr_i[ADDR_W-1:OFF_W];
        ctl_o.lane     = lane_of(off, order_i);
        ctl_o.misalign = (size_i == ACC_WORD) && (off != '0);
        ctl_o.strobe   = '0;
        if (we_i && !ctl_o.misalign) begin
            if (size_i == ACC_WORD) ctl_o.strobe = '1;
            else                    ctl_o.strobe = LANES'(1) << ctl_o.lane;
        end
        wbus_o = (size_i == ACC_WORD) ? wdata_i : {LANES{wdata_i[LANE_W-1:0]}};
    end

endmodule

// File: rtl/edm_store.sv
module edm_store
    import edm_pkg::*;
#(
    parameter int unsigned IDX_W = 6,
    localparam int unsigned DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [LANES-1:0]  strobe_i,
    input  logic [WORD_W-1:0] wbus_i,
    input  logic              misalign_i,
    input  acc_size_e         size_i,
    output logic [WORD_W-1:0] rd_word_o
);

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (strobe_i[l]) mem[idx_i][l*LANE_W +: LANE_W] <= wbus_i[l*LANE_W +: LANE_W];
            end
        end
    end

    assign rd_word_o = mem[idx_i];

    // R7: a flagged word access never reaches the array
    a_r7_no_write_misaligned: assert property (@(posedge clk) disable iff (rst)
        misalign_i |-> (strobe_i == '0));

    // R6: a byte store touches exactly one lane
    a_r6_single_lane: assert property (@(posedge clk) disable iff (rst)
        (size_i == ACC_BYTE && strobe_i != '0) |-> ($countones(strobe_i) == 1));

    // R2: a full-word store lands intact
    a_r2_word_lands: assert property (@(posedge clk) disable iff (rst)
        (&strobe_i) |=> (mem[$past(idx_i)] == $past(wbus_i)));

endmodule

// File: rtl/edm_read_fmt.sv
module edm_read_fmt
    import edm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] rd_word_i,
    input  logic [OFF_W-1:0]  lane_i,
    input  acc_size_e         size_i,
    output logic [WORD_W-1:0] rdata_o
);

    always_comb begin
        if (size_i == ACC_WORD) rdata_o = rd_word_i;
        else                    rdata_o = sext_byte(rd_word_i[lane_i*LANE_W +: LANE_W]);
    end

    // R5: byte results are sign-extended
    a_r5_sign_extend: assert property (@(posedge clk) disable iff (rst)
        (size_i == ACC_BYTE) |-> (rdata_o[WORD_W-1:LANE_W] == {(WORD_W-LANE_W){rdata_o[LANE_W-1]}}));

endmodule

// File: rtl/endian_data_mem.sv
module endian_data_mem
    import edm_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              big_endian_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              size_i,
    input  logic              we_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    output logic              misalign_o
);

    localparam int unsigned IDX_W = ADDR_W - OFF_W;

    acc_size_e         size;
    byte_order_e       order;
    logic [IDX_W-1:0]  idx;
    lane_ctl_t         ctl;
    logic [WORD_W-1:0] wbus;
    logic [WORD_W-1:0] rd_word;

    assign size  = acc_size_e'(size_i);
    assign order = byte_order_e'(big_endian_i);

    edm_lane_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr_i  (addr_i),
        .size_i  (size),
        .order_i (order),
        .we_i    (we_i),
        .wdata_i (wdata_i),
        .idx_o   (idx),
        .ctl_o   (ctl),
        .wbus_o  (wbus)
    );

    edm_store #(.IDX_W(IDX_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .idx_i      (idx),
        .strobe_i   (ctl.strobe),
        .wbus_i     (wbus),
        .misalign_i (ctl.misalign),
        .size_i     (size),
        .rd_word_o  (rd_word)
    );

    edm_read_fmt u_fmt (
        .clk       (clk),
        .rst       (rst),
        .rd_word_i (rd_word),
        .lane_i    (ctl.lane),
        .size_i    (size),
        .rdata_o   (rdata_o)
    );

    assign misalign_o = ctl.misalign;

    // R7: byte accesses never raise the flag
    a_r7_byte_never_flagged: assert property (@(posedge clk) disable iff (rst)
        (size_i == 1'b0) |-> !misalign_o);

endmodule

// File: tb/endian_data_mem_bench.sv
module endian_data_mem_bench;

    localparam int ADDR_W = 8;
    localparam int NWORDS = 1 << (ADDR_W - 2);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              big_endian_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic              size_i = 1'b0;
    logic              we_i = 1'b0;
    logic [31:0]       wdata_i = '0;
    logic [31:0]       rdata_o;
    logic              misalign_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [31:0] model [NWORDS];

    always #4 clk = ~clk;

    endian_data_mem #(.ADDR_W(ADDR_W)) u_endian_data_mem (
        .clk(clk), .rst(rst), .big_endian_i(big_endian_i), .addr_i(addr_i),
        .size_i(size_i), .we_i(we_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .misalign_o(misalign_o)
    );

    function automatic int lane_for(logic [1:0] k, logic big);
        return big ? (3 - int'(k)) : int'(k);
    endfunction

    function automatic logic [31:0] exp_read(logic [ADDR_W-1:0] a, logic sz, logic big);
        logic [31:0] w;
        logic [7:0]  b;
        w = model[a >> 2];
        if (sz) return w;
        b = w[lane_for(a[1:0], big)*8 +: 8];
        return {{24{b[7]}}, b};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_write(logic [ADDR_W-1:0] a, logic sz, logic [31:0] d, logic big);
        logic mis;
        int   ln;
        @(negedge clk);
        addr_i = a; size_i = sz; wdata_i = d; big_endian_i = big; we_i = 1'b1;
        #1;
        mis = sz && (a[1:0] != 2'b00);
        check("R7 flag", {31'b0, misalign_o}, {31'b0, mis});
        @(posedge clk);
        if (!mis) begin
            if (sz) model[a >> 2] = d;
            else begin
                ln = lane_for(a[1:0], big);
                model[a >> 2][ln*8 +: 8] = d[7:0];
            end
        end
        #1 we_i = 1'b0;
    endtask

    task automatic do_read(string req, logic [ADDR_W-1:0] a, logic sz, logic big);
        @(negedge clk);
        we_i = 1'b0; addr_i = a; size_i = sz; big_endian_i = big;
        #1;
        check(req, rdata_o, exp_read(a, sz, big));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got 0x00000000 expected 0x00000001");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] tmp;
        tmp = $urandom(32'h5EED);
        for (int i = 0; i < NWORDS; i++) model[i] = 32'h0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: cleared after reset
        do_read("R1 reset", 8'h00, 1'b1, 1'b0);
        do_read("R1 reset", 8'hFC, 1'b1, 1'b1);
        do_read("R1 reset", 8'h57, 1'b0, 1'b0);

        // R2: word store/load in both orders
        do_write(8'h00, 1'b1, 32'h11223344, 1'b0);
        do_read("R2 word little", 8'h00, 1'b1, 1'b0);
        do_read("R2 word big", 8'h00, 1'b1, 1'b1);
        check("R3 addr1 little", (exp_read(8'h01, 1'b0, 1'b0)), 32'h00000033);
        do_read("R3 addr1 little", 8'h01, 1'b0, 1'b0);
        do_read("R4 addr1 big", 8'h01, 1'b0, 1'b1);
        @(negedge clk); addr_i = 8'h01; size_i = 1'b0; big_endian_i = 1'b1; #1;
        check("R4 addr1 big literal", rdata_o, 32'h00000022);
        big_endian_i = 1'b0; #1;
        check("R3 addr1 little literal", rdata_o, 32'h00000033);
        for (int k = 0; k < 4; k++) begin
            do_read("R3 lanes", 8'(k), 1'b0, 1'b0);
            do_read("R4 lanes", 8'(k), 1'b0, 1'b1);
        end

        // R5: sign extension
        do_write(8'h10, 1'b1, 32'h80FF017F, 1'b0);
        @(negedge clk); addr_i = 8'h13; size_i = 1'b0; big_endian_i = 1'b0; #1;
        check("R5 negative byte", rdata_o, 32'hFFFFFF80);
        addr_i = 8'h10; #1;
        check("R5 positive byte", rdata_o, 32'h0000007F);

        // R6: byte store lane isolation
        do_write(8'h22, 1'b0, 32'hFFFFFFA5, 1'b0);
        do_read("R6 little byte store", 8'h20, 1'b1, 1'b0);
        do_write(8'h10, 1'b1, 32'hCAFEBABE, 1'b0);
        do_write(8'h11, 1'b0, 32'h0000005A, 1'b1);
        @(negedge clk); addr_i = 8'h10; size_i = 1'b1; #1;
        check("R6 big byte store", rdata_o, 32'hCA5ABABE);

        // R7: misaligned word store dropped
        do_write(8'h32, 1'b1, 32'hDEADBEEF, 1'b0);
        do_read("R7 no write", 8'h30, 1'b1, 1'b0);
        @(negedge clk); addr_i = 8'h30; size_i = 1'b1; #1;
        check("R7 word intact", rdata_o, 32'h00000000);

        // R8: store invisible before its edge
        @(negedge clk);
        addr_i = 8'h40; size_i = 1'b1; wdata_i = 32'h0BADF00D; we_i = 1'b1; big_endian_i = 1'b0;
        #1 check("R8 before edge", rdata_o, 32'h00000000);
        @(posedge clk); model[16] = 32'h0BADF00D;
        #1 check("R8 after edge", rdata_o, 32'h0BADF00D);
        we_i = 1'b0;

        // Random mix
        for (int n = 0; n < 600; n++) begin
            logic [ADDR_W-1:0] a;
            logic sz, bg;
            a  = ADDR_W'($urandom_range(0, 63));
            sz = 1'($urandom_range(0, 1));
            bg = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 2) == 0) do_write(a, sz, $urandom(), bg);
            else do_read(sz ? "R2 random word" : (bg ? "R4 random byte" : "R3 random byte"), a, sz, bg);
        end

        // R1: reset clears again
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        for (int i = 0; i < NWORDS; i++) model[i] = 32'h0;
        do_read("R1 re-reset", 8'h40, 1'b1, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule